// File: doc/BRIEF.md
# Host Address Decode Router

The router sorts every memory transaction seen by a host bridge into one of five destinations. It looks at the 32-bit address and at who issued the transaction: the host processor or an I/O link. It also looks at whether the host is in system-management mode (SMM) and at the cycle type. The destinations are main memory, the downstream I/O link, the interrupt-message path toward the host bus, the configuration-space target and immediate termination. For accesses that land in the high SMM segment, the router also produces the translated low-memory address. It raises an illegal-access flag whenever it terminates a transaction.

A caller presents one transaction per cycle with `valid_i`. The route, the address to forward and the illegal flag are registered and appear one clock later, marked by `valid_o`. They hold their values until the next strobe. Fixed windows cover the interrupt-controller range, the high SMM segment, the inbound interrupt range and the boot firmware area. The configuration window is set by a 4-bit base input, and a top-of-memory input splits all remaining addresses between memory and the I/O link.

Top module: `haddr_router`

## Requirements
- R1: When addr[31:28] equals `cfg_base_i`, the route is configuration (code 4) and the address passes through unchanged, whatever the originator, mode or cycle. This window has the highest priority.
- R2: A write (cycle code 1) from the I/O link (origin 1) to 0xFEE0_0000–0xFEEF_FFFF is routed to the interrupt path (code 2). A read from the I/O link or any host access to that range follows the default rule instead.
- R3: With `hseg_en_i` high, a host access (origin 0) in SMM to 0xFEDA_0000–0xFEDB_FFFF goes to memory (code 0). The forwarded address is 0x000A_0000 plus the offset into the window, which means the low 17 bits are kept.
- R4: With `hseg_en_i` high, a non-SMM host read (code 0) or write (code 1) to that window is terminated (code 3) and `illegal_o` is set.
- R5: With `hseg_en_i` high, a non-SMM host writeback (code 2) or implicit writeback (code 3) to that window goes to memory with the same remapping as R3, and `illegal_o` stays low.
- R6: With `hseg_en_i` high, any I/O-link access to that window is terminated with `illegal_o` set, whatever the SMM flag or cycle type.
- R7: Accesses to 0xFEC0_0000–0xFEC7_FFFF go to the I/O link (code 1), even when they lie below top of memory.
- R8: Accesses to 0xFFE0_0000–0xFFFF_FFFF go to the I/O link, even when they lie below top of memory.
- R9: Any address that no rule above claims goes to memory if it is below `tom_i` and to the I/O link otherwise. This includes the high-segment window when `hseg_en_i` is low.
- R10: All outputs are updated one clock after `valid_i`, and `valid_o` is high for exactly that cycle. With `valid_i` low, the route, address and flag hold their previous values. After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Transaction strobe |
| addr_i | input | 32 | Transaction address |
| origin_i | input | 1 | 0 host, 1 I/O link |
| smm_i | input | 1 | Host is in SMM |
| cyc_i | input | 2 | 0 read, 1 write, 2 writeback, 3 implicit writeback |
| hseg_en_i | input | 1 | High SMM segment enable |
| cfg_base_i | input | 4 | Configuration window base, address bits [31:28] |
| tom_i | input | 32 | Top of main memory (exclusive) |
| valid_o | output | 1 | Result valid |
| route_o | output | 3 | Destination: 0 mem, 1 I/O link, 2 interrupt, 3 terminate, 4 config |
| addr_o | output | 32 | Forwarded, possibly remapped, address |
| illegal_o | output | 1 | Access terminated as invalid |

## Verification
The bench builds the router with its default parameters: 32-bit addresses and the fixed window bases and sizes above. That is the only set under which the window edges are meaningful. The base and top-of-memory inputs are changed at run time. The configuration base is moved to 0xF so that it covers every fixed window, which shows the priority order. The top of memory is raised to its maximum so that the interrupt-controller and boot firmware windows can be told apart from the default route at their exact boundaries.

// File: rtl/haddr_pkg.sv
package haddr_pkg;
  typedef enum logic [2:0] {
    ROUTE_MEM  = 3'd0,
    ROUTE_IO   = 3'd1,
    ROUTE_IRQ  = 3'd2,
    ROUTE_TERM = 3'd3,
    ROUTE_CFG  = 3'd4
  } route_e;

  typedef enum logic [1:0] {
    CYC_RD  = 2'd0,
    CYC_WR  = 2'd1,
    CYC_WB  = 2'd2,
    CYC_IWB = 2'd3
  } cyc_e;
endpackage

// File: rtl/haddr_win_match.sv
module haddr_win_match #(
  parameter int          AW      = 32,
  parameter int          SZ_LOG2 = 20,
  parameter logic [31:0] BASE    = 32'h0
) (
  input  logic [AW-SZ_LOG2-1:0] addr_hi_i,
  output logic                  hit_o
);
  localparam logic [AW-SZ_LOG2-1:0] BaseHi = BASE[AW-1:SZ_LOG2];
  assign hit_o = (addr_hi_i == BaseHi);
endmodule

// File: rtl/haddr_hseg_xlate.sv
module haddr_hseg_xlate #(
  parameter int          AW      = 32,
  parameter int          SZ_LOG2 = 17,
  parameter logic [31:0] TARGET  = 32'h000A_0000
) (
  input  logic [SZ_LOG2-1:0] offs_i,
  output logic [AW-1:0]      addr_o
);
  localparam logic [AW-SZ_LOG2-1:0] TgtHi = TARGET[AW-1:SZ_LOG2];
  assign addr_o = {TgtHi, offs_i};
endmodule

// File: rtl/haddr_route_sel.sv
module haddr_route_sel
  import haddr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          cfg_hit_i,
  input  logic          irq_hit_i,
  input  logic          hseg_hit_i,
  input  logic          apic_hit_i,
  input  logic          boot_hit_i,
  input  logic          origin_i,
  input  logic          smm_i,
  input  cyc_e          cyc_i,
  input  logic          hseg_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] tom_i,
  output route_e        route_o,
  output logic          illegal_o,
  output logic          remap_o
);
  logic wb_cyc;
  assign wb_cyc = (cyc_i == CYC_WB) || (cyc_i == CYC_IWB);

  always_comb begin
    route_o   = (addr_i < tom_i) ? ROUTE_MEM : ROUTE_IO;
    illegal_o = 1'b0;
    remap_o   = 1'b0;
    if (cfg_hit_i) begin
      route_o = ROUTE_CFG;
    end else if (irq_hit_i && origin_i && cyc_i == CYC_WR) begin
      route_o = ROUTE_IRQ;
    end else if (hseg_hit_i && hseg_en_i) begin
      if (!origin_i && (smm_i || wb_cyc)) begin
        route_o = ROUTE_MEM;
        remap_o = 1'b1;
      end else begin
        route_o   = ROUTE_TERM;
        illegal_o = 1'b1;
      end
    end else if (apic_hit_i || boot_hit_i) begin
      route_o = ROUTE_IO;
    end
  end
endmodule

// File: rtl/haddr_router.sv
module haddr_router
  import haddr_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          CFG_W      = 4,
  parameter logic [31:0] APIC_BASE  = 32'hFEC0_0000,
  parameter int          APIC_LOG2  = 19,
  parameter logic [31:0] HSEG_BASE  = 32'hFEDA_0000,
  parameter int          HSEG_LOG2  = 17,
  parameter logic [31:0] HSEG_TGT   = 32'h000A_0000,
  parameter logic [31:0] IRQ_BASE   = 32'hFEE0_0000,
  parameter int          IRQ_LOG2   = 20,
  parameter logic [31:0] BOOT_BASE  = 32'hFFE0_0000,
  parameter int          BOOT_LOG2  = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             origin_i,
  input  logic             smm_i,
  input  logic [1:0]       cyc_i,
  input  logic             hseg_en_i,
  input  logic [CFG_W-1:0] cfg_base_i,
  input  logic [AW-1:0]    tom_i,
  output logic             valid_o,
  output logic [2:0]       route_o,
  output logic [AW-1:0]    addr_o,
  output logic             illegal_o
);
  logic          cfg_hit, irq_hit, hseg_hit, apic_hit, boot_hit;
  logic          remap, illegal_d;
  route_e        route_d;
  logic [AW-1:0] hseg_addr, addr_d;

  assign cfg_hit = (addr_i[AW-1:AW-CFG_W] == cfg_base_i);

  haddr_win_match #(.AW(AW), .SZ_LOG2(IRQ_LOG2), .BASE(IRQ_BASE)) u_irq (
    .addr_hi_i(addr_i[AW-1:IRQ_LOG2]), .hit_o(irq_hit));
  haddr_win_match #(.AW(AW), .SZ_LOG2(HSEG_LOG2), .BASE(HSEG_BASE)) u_hseg (
    .addr_hi_i(addr_i[AW-1:HSEG_LOG2]), .hit_o(hseg_hit));
  haddr_win_match #(.AW(AW), .SZ_LOG2(APIC_LOG2), .BASE(APIC_BASE)) u_apic (
    .addr_hi_i(addr_i[AW-1:APIC_LOG2]), .hit_o(apic_hit));
  haddr_win_match #(.AW(AW), .SZ_LOG2(BOOT_LOG2), .BASE(BOOT_BASE)) u_boot (
    .addr_hi_i(addr_i[AW-1:BOOT_LOG2]), .hit_o(boot_hit));

  haddr_hseg_xlate #(.AW(AW), .SZ_LOG2(HSEG_LOG2), .TARGET(HSEG_TGT)) u_xlate (
    .offs_i(addr_i[HSEG_LOG2-1:0]), .addr_o(hseg_addr));

  haddr_route_sel #(.AW(AW)) u_sel (
    .cfg_hit_i (cfg_hit),
    .irq_hit_i (irq_hit),
    .hseg_hit_i(hseg_hit),
    .apic_hit_i(apic_hit),
    .boot_hit_i(boot_hit),
    .origin_i  (origin_i),
    .smm_i     (smm_i),
    .cyc_i     (cyc_e'(cyc_i)),
    .hseg_en_i (hseg_en_i),
    .addr_i    (addr_i),
    .tom_i     (tom_i),
    .route_o   (route_d),
    .illegal_o (illegal_d),
    .remap_o   (remap)
  );

  assign addr_d = remap ? hseg_addr : addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      route_o   <= 3'd0;
      addr_o    <= '0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        route_o   <= route_d;
        addr_o    <= addr_d;
        illegal_o <= illegal_d;
      end
    end
  end
endmodule

// File: rtl/haddr_router_chk.sv
module haddr_router_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [31:0] addr_i,
  input logic        origin_i,
  input logic [1:0]  cyc_i,
  input logic        hseg_en_i,
  input logic [3:0]  cfg_base_i,
  input logic        valid_o,
  input logic [2:0]  route_o,
  input logic [31:0] addr_o,
  input logic        illegal_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_valid_lat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (valid_o == $past(valid_i)));

  assert_illegal_term_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (route_o == 3'd3));

  assert_irq_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && valid_o && route_o == 3'd2) |->
      ($past(origin_i) && $past(cyc_i) == 2'd1));

  assert_io_hseg_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i) && $past(origin_i) && $past(hseg_en_i) &&
     $past(addr_i[31:17]) == 15'h7F6D && $past(addr_i[31:28]) != $past(cfg_base_i))
      |-> illegal_o);

  assert_remap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && valid_o && route_o == 3'd0 && $past(hseg_en_i) &&
     $past(addr_i[31:17]) == 15'h7F6D)
      |-> (addr_o == {15'h0005, $past(addr_i[16:0])}));
endmodule

bind haddr_router haddr_router_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .addr_i    (addr_i),
  .origin_i  (origin_i),
  .cyc_i     (cyc_i),
  .hseg_en_i (hseg_en_i),
  .cfg_base_i(cfg_base_i),
  .valid_o   (valid_o),
  .route_o   (route_o),
  .addr_o    (addr_o),
  .illegal_o (illegal_o)
);

// File: tb/tb_haddr_router.sv
module tb_haddr_router;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic        origin_i = 1'b0;
  logic        smm_i = 1'b0;
  logic [1:0]  cyc_i = 2'd0;
  logic        hseg_en_i = 1'b1;
  logic [3:0]  cfg_base_i = 4'hE;
  logic [31:0] tom_i = 32'h4000_0000;
  logic        valid_o;
  logic [2:0]  route_o;
  logic [31:0] addr_o;
  logic        illegal_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  haddr_router dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic txn(input string tag, input logic [31:0] a, input logic org, input logic smm,
                     input logic [1:0] cyc, input logic [2:0] er, input logic [31:0] ea,
                     input logic ei);
    @(negedge clk_i);
    addr_i = a; origin_i = org; smm_i = smm; cyc_i = cyc; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk({tag, " valid"}, {31'd0, valid_o}, 32'd1);
    chk({tag, " route"}, {29'd0, route_o}, {29'd0, er});
    chk({tag, " addr"}, addr_o, ea);
    chk({tag, " illegal"}, {31'd0, illegal_o}, {31'd0, ei});
  endtask

  task automatic t_reset;
    chk("R10 reset valid", {31'd0, valid_o}, 32'd0);
    chk("R10 reset route", {29'd0, route_o}, 32'd0);
    chk("R10 reset addr", addr_o, 32'd0);
    chk("R10 reset illegal", {31'd0, illegal_o}, 32'd0);
  endtask

  task automatic t_cfg;
    txn("R1 cfg hit", 32'hE123_4567, 0, 0, 2'd0, 3'd4, 32'hE123_4567, 0);
    cfg_base_i = 4'hF;
    txn("R1 cfg over irq", 32'hFEE0_0010, 1, 0, 2'd1, 3'd4, 32'hFEE0_0010, 0);
    txn("R1 cfg over hseg", 32'hFEDA_0020, 1, 0, 2'd1, 3'd4, 32'hFEDA_0020, 0);
    txn("R1 cfg over boot", 32'hFFF0_0000, 0, 0, 2'd0, 3'd4, 32'hFFF0_0000, 0);
    cfg_base_i = 4'hE;
  endtask

  task automatic t_irq;
    txn("R2 io write", 32'hFEE0_1000, 1, 0, 2'd1, 3'd2, 32'hFEE0_1000, 0);
    txn("R2 io read", 32'hFEE0_1000, 1, 0, 2'd0, 3'd1, 32'hFEE0_1000, 0);
    txn("R2 host write", 32'hFEEF_FFFC, 0, 0, 2'd1, 3'd1, 32'hFEEF_FFFC, 0);
  endtask

  task automatic t_hseg;
    txn("R3 smm low", 32'hFEDA_1234, 0, 1, 2'd0, 3'd0, 32'h000A_1234, 0);
    txn("R3 smm top", 32'hFEDB_FFFC, 0, 1, 2'd1, 3'd0, 32'h000B_FFFC, 0);
    txn("R4 nonsmm write", 32'hFEDA_0040, 0, 0, 2'd1, 3'd3, 32'hFEDA_0040, 1);
    txn("R4 nonsmm read", 32'hFEDB_8000, 0, 0, 2'd0, 3'd3, 32'hFEDB_8000, 1);
    txn("R5 writeback", 32'hFEDB_0080, 0, 0, 2'd2, 3'd0, 32'h000B_0080, 0);
    txn("R5 implicit wb", 32'hFEDA_0004, 0, 0, 2'd3, 3'd0, 32'h000A_0004, 0);
    txn("R6 io write", 32'hFEDA_0000, 1, 0, 2'd1, 3'd3, 32'hFEDA_0000, 1);
    txn("R6 io wb smm", 32'hFEDB_0100, 1, 1, 2'd2, 3'd3, 32'hFEDB_0100, 1);
  endtask

  task automatic t_fixed;
    tom_i = 32'hFFFF_FFFF;
    txn("R7 apic in", 32'hFEC7_FFFF, 0, 0, 2'd0, 3'd1, 32'hFEC7_FFFF, 0);
    txn("R7 apic out", 32'hFEC8_0000, 0, 0, 2'd0, 3'd0, 32'hFEC8_0000, 0);
    txn("R8 boot in", 32'hFFE0_0000, 0, 0, 2'd0, 3'd1, 32'hFFE0_0000, 0);
    txn("R8 boot out", 32'hFFDF_FFFF, 0, 0, 2'd0, 3'd0, 32'hFFDF_FFFF, 0);
  endtask

  task automatic t_default;
    hseg_en_i = 1'b0;
    txn("R9 hseg off mem", 32'hFEDA_1234, 0, 1, 2'd0, 3'd0, 32'hFEDA_1234, 0);
    tom_i = 32'h4000_0000;
    txn("R9 hseg off io", 32'hFEDA_1234, 0, 0, 2'd1, 3'd1, 32'hFEDA_1234, 0);
    txn("R9 below tom", 32'h3FFF_FFFC, 0, 0, 2'd0, 3'd0, 32'h3FFF_FFFC, 0);
    txn("R9 at tom", 32'h4000_0000, 1, 0, 2'd1, 3'd1, 32'h4000_0000, 0);
    hseg_en_i = 1'b1;
  endtask

  task automatic t_hold;
    txn("R10 setup", 32'hFEDA_0040, 0, 0, 2'd1, 3'd3, 32'hFEDA_0040, 1);
    @(negedge clk_i);
    addr_i = 32'h1000_0000; origin_i = 1'b0; cyc_i = 2'd0;
    @(negedge clk_i);
    chk("R10 hold valid", {31'd0, valid_o}, 32'd0);
    chk("R10 hold route", {29'd0, route_o}, 32'd3);
    chk("R10 hold addr", addr_o, 32'hFEDA_0040);
    chk("R10 hold illegal", {31'd0, illegal_o}, 32'd1);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_cfg();
    t_irq();
    t_hseg();
    t_fixed();
    t_default();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule